// File: doc/BRIEF.md
# Enhanced Parallel Port Transfer Gate

This block sits between a host register bus and a byte-serial peripheral channel of an enhanced parallel port. It holds the data and control registers of the port, presents the live status lines with a sticky timeout flag in bit 0, and decides whether a host access to the fast-transfer address register (offset 3) or data register (offset 4) may start a peripheral transaction. The decision depends on the direction bit and the four signal bits of the control register.

Accesses at offset 4 may be 8, 16 or 32 bits wide. A wide access becomes one peripheral transaction of 2 or 4 bytes in little-endian order. The host request is held off until the whole transaction completes. Any byte that returns an error aborts the rest of the transaction and latches the timeout flag. Writes that would not change the data or control register are suppressed. A control write that flips the direction bit first sends a direction-change request and then sends the control value. A separate window selected by `ecp_sel_i` ignores writes and reads back 0xFF.

Top module: `epp_gate`

## Requirements
- R1: After reset, or on a reset asserted mid-transfer, the peripheral request is low, control reads 0xCC, the data register reads 0xFF and status bit 0 (timeout) reads 0.
- R2: A write to offset 3 or 4 starts a peripheral write (op 0 for address, op 1 for data) only when control AND 0x2F equals 0x04. Otherwise no byte is sent.
- R3: A read from offset 3 or 4 starts a peripheral read only when control AND 0x2F equals 0x24. Otherwise it returns all ones over the access width (8, 16 or 32 bits; size code 0, 1, 2) and zero above that width.
- R4: A 16-bit or 32-bit access at offset 4 is one transaction with a byte count of 2 or 4, sent or assembled least-significant byte first.
- R5: A peripheral byte that returns an error ends the transaction, sets the timeout flag, and leaves any read bytes not yet received (including the failed one) at 0xFF. The flag stays set through later successful transfers.
- R6: A status read (offset 1) returns the live lines in bits 7:1 and the timeout flag in bit 0. A status write with bit 0 = 1 clears the flag, and one with bit 0 = 0 leaves it unchanged.
- R7: A data write (offset 0) or a control write (offset 2, bits 7:6 forced to 1) whose value equals the held value sends no byte. A differing value sends one byte (op 2 for data, op 3 for control).
- R8: A control write that changes bit 5 (direction) sends a direction request (op 4, byte = new direction bit) before the control byte (op 3, byte = value with bits 7:6 set).
- R9: With `ecp_sel_i` high, writes send no byte and change no register, and reads return 0xFF.
- R10: `ack_o` is a single-cycle pulse. A register-only access is acknowledged one cycle after the request. A peripheral access is acknowledged only after its last byte completes, and the peripheral request and op stay stable until each byte completes.
- R11: A data read returns `pdata_i` when the direction bit is 1 and the held data register when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host access request, held until ack |
| we_i | input | 1 | 1 = write, 0 = read |
| ecp_sel_i | input | 1 | Selects the extended-mode register window |
| addr_i | input | 3 | Register offset |
| size_i | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| wdata_i | input | 32 | Host write data |
| ack_o | output | 1 | Access complete pulse |
| rdata_o | output | 32 | Read data, valid with ack_o |
| status_i | input | 7 | Live peripheral status lines, bits 7:1 |
| pdata_i | input | 8 | Live peripheral data lines |
| p_req_o | output | 1 | Peripheral byte request |
| p_op_o | output | 3 | Transaction kind (0 addr, 1 data, 2 data reg, 3 control, 4 direction) |
| p_we_o | output | 1 | 1 = byte to peripheral |
| p_cnt_o | output | 3 | Bytes in this transaction |
| p_byte_o | output | 8 | Byte being written |
| p_rbyte_i | input | 8 | Byte returned by the peripheral |
| p_done_i | input | 1 | Current byte complete |
| p_err_i | input | 1 | Current byte failed, valid with p_done_i |

## Verification
The bench goes after the two gating patterns with control values that differ only in the direction bit. A gate that masked the wrong bits would send address bytes while reading is selected, or would return a peripheral byte where all ones belong. Wide reads with the gate closed must come back masked to the access width, and wide writes must come out least-significant byte first. A byte-order swap or an overwide mask shows up directly in the logged bytes or in the read value. An error injected on the first byte of a word read must cut the transfer to one byte and latch a flag that survives a later good transfer and a zero-bit status write. The direction-change write must log a direction request ahead of the control byte, and a reset during a transfer must drop the request and restore 0xCC.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [2:0] {
    OP_EPP_ADDR = 3'd0,
    OP_EPP_DATA = 3'd1,
    OP_DATA     = 3'd2,
    OP_CTRL     = 3'd3,
    OP_DIR      = 3'd4
  } p_op_e;

  localparam logic [2:0] OFF_DATA  = 3'd0;
  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_CTRL  = 3'd2;
  localparam logic [2:0] OFF_EADDR = 3'd3;
  localparam logic [2:0] OFF_EDATA = 3'd4;

  localparam logic [7:0] CTRL_GATE_MASK = 8'h2F;
  localparam logic [7:0] CTRL_EPP_WR    = 8'h04;
  localparam logic [7:0] CTRL_EPP_RD    = 8'h24;
  localparam logic [7:0] CTRL_RESET     = 8'hCC;
  localparam logic [7:0] CTRL_FIXED     = 8'hC0;
  localparam logic [7:0] DATA_RESET     = 8'hFF;
  localparam int         DIR_BIT        = 5;
endpackage

// File: rtl/epp_permit.sv
module epp_permit
  import epp_pkg::*;
(
  input  logic [7:0] ctrl_i,
  output logic       wr_ok_o,
  output logic       rd_ok_o
);
  logic [7:0] masked;
  assign masked  = ctrl_i & CTRL_GATE_MASK;
  assign wr_ok_o = (masked == CTRL_EPP_WR);
  assign rd_ok_o = (masked == CTRL_EPP_RD);
endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq #(
  parameter  int NB = 4,
  localparam int CW = $clog2(NB + 1),
  localparam int IW = (NB > 1) ? $clog2(NB) : 1,
  localparam int DW = NB * 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic          we_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [DW-1:0] wbuf_i,
  input  logic          p_done_i,
  input  logic          p_err_i,
  input  logic [7:0]    p_rbyte_i,
  output logic          p_req_o,
  output logic [2:0]    p_op_o,
  output logic          p_we_o,
  output logic [CW-1:0] p_cnt_o,
  output logic [7:0]    p_byte_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rbuf_o
);
  logic          busy_q, we_q;
  logic [2:0]    op_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] wbuf_q;
  logic          last, launch, take;

  assign launch = start_i && !busy_q;
  assign take   = busy_q && p_done_i;
  assign last   = (CW'(idx_q) + CW'(1)) == cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      op_q   <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      wbuf_q <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      we_q   <= we_i;
      op_q   <= op_i;
      idx_q  <= '0;
      cnt_q  <= cnt_i;
      wbuf_q <= wbuf_i;
    end else if (take) begin
      if (p_err_i || last) busy_q <= 1'b0;
      else                 idx_q  <= idx_q + IW'(1);
    end
  end

  // per-byte read capture; bytes beyond the count read as zero
  for (genvar g = 0; g < NB; g++) begin : g_rbyte
    logic [7:0] rb_q;
    logic       hit;
    assign hit = take && !p_err_i && (idx_q == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     rb_q <= '0;
      else if (launch) rb_q <= (CW'(g) < cnt_i) ? 8'hFF : 8'h00;
      else if (hit)    rb_q <= p_rbyte_i;
    end
    // forward the completing byte so the top can latch on the done edge
    assign rbuf_o[g*8 +: 8] = hit ? p_rbyte_i : rb_q;
  end

  assign p_req_o  = busy_q;
  assign p_op_o   = op_q;
  assign p_we_o   = we_q;
  assign p_cnt_o  = cnt_q;
  assign p_byte_o = wbuf_q[{idx_q, 3'b000} +: 8];
  assign done_o   = take && (p_err_i || last);
  assign err_o    = take && p_err_i;
endmodule

// File: rtl/epp_gate.sv
module epp_gate
  import epp_pkg::*;
#(
  parameter  int HDW = 32,
  localparam int NB  = HDW / 8,
  localparam int CW  = $clog2(NB + 1),
  localparam int LW  = $clog2(NB),
  localparam int SW  = (LW > 0) ? $clog2(LW + 1) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic           we_i,
  input  logic           ecp_sel_i,
  input  logic [2:0]     addr_i,
  input  logic [SW-1:0]  size_i,
  input  logic [HDW-1:0] wdata_i,
  output logic           ack_o,
  output logic [HDW-1:0] rdata_o,
  input  logic [7:1]     status_i,
  input  logic [7:0]     pdata_i,
  output logic           p_req_o,
  output logic [2:0]     p_op_o,
  output logic           p_we_o,
  output logic [CW-1:0]  p_cnt_o,
  output logic [7:0]     p_byte_o,
  input  logic [7:0]     p_rbyte_i,
  input  logic           p_done_i,
  input  logic           p_err_i
);
  logic           ack_q, tmo_q, pend_q;
  logic [7:0]     data_q, ctrl_q, data_d, ctrl_d, ctrl_v;
  logic [HDW-1:0] rdata_q, imm_rd, wmask, rbuf;
  logic           accept, imm, tmo_clr, pend_set;
  logic           s_start, s_we, seq_done, seq_err, wr_ok, rd_ok;
  p_op_e          s_op;
  logic [CW-1:0]  s_cnt, acc_nb;
  logic [HDW-1:0] s_wbuf;
  logic [SW-1:0]  sz;

  epp_permit i_permit (.ctrl_i(ctrl_q), .wr_ok_o(wr_ok), .rd_ok_o(rd_ok));

  epp_byte_seq #(.NB(NB)) i_seq (
    .clk_i, .rst_ni,
    .start_i(s_start), .op_i(s_op), .we_i(s_we), .cnt_i(s_cnt), .wbuf_i(s_wbuf),
    .p_done_i, .p_err_i, .p_rbyte_i,
    .p_req_o, .p_op_o, .p_we_o, .p_cnt_o, .p_byte_o,
    .done_o(seq_done), .err_o(seq_err), .rbuf_o(rbuf)
  );

  assign accept = req_i && !ack_q && !p_req_o && !pend_q;
  assign sz     = (size_i > SW'(LW)) ? SW'(LW) : size_i;
  assign acc_nb = CW'(1) << sz;
  assign ctrl_v = wdata_i[7:0] | CTRL_FIXED;

  always_comb begin
    for (int i = 0; i < NB; i++) wmask[i*8 +: 8] = (i < int'(acc_nb)) ? 8'hFF : 8'h00;
  end

  always_comb begin
    s_start  = 1'b0;
    s_op     = OP_DATA;
    s_we     = 1'b1;
    s_cnt    = CW'(1);
    s_wbuf   = wdata_i;
    imm      = 1'b1;
    imm_rd   = '0;
    data_d   = data_q;
    ctrl_d   = ctrl_q;
    tmo_clr  = 1'b0;
    pend_set = 1'b0;
    if (accept) begin
      if (ecp_sel_i) begin
        if (!we_i) imm_rd = HDW'(8'hFF);
      end else begin
        unique case (addr_i)
          OFF_DATA: begin
            if (!we_i) imm_rd = HDW'(ctrl_q[DIR_BIT] ? pdata_i : data_q);
            else if (wdata_i[7:0] != data_q) begin
              s_start = 1'b1; imm = 1'b0; data_d = wdata_i[7:0];
            end
          end
          OFF_STAT: begin
            if (we_i) tmo_clr = wdata_i[0];
            else      imm_rd  = HDW'({status_i, tmo_q});
          end
          OFF_CTRL: begin
            if (!we_i) imm_rd = HDW'(ctrl_q);
            else if (ctrl_v != ctrl_q) begin
              s_start = 1'b1; imm = 1'b0; ctrl_d = ctrl_v;
              if (ctrl_v[DIR_BIT] != ctrl_q[DIR_BIT]) begin
                s_op     = OP_DIR;
                s_wbuf   = HDW'(ctrl_v[DIR_BIT]);
                pend_set = 1'b1;
              end else begin
                s_op   = OP_CTRL;
                s_wbuf = HDW'(ctrl_v);
              end
            end
          end
          OFF_EADDR, OFF_EDATA: begin
            s_op  = (addr_i == OFF_EADDR) ? OP_EPP_ADDR : OP_EPP_DATA;
            s_we  = we_i;
            s_cnt = (addr_i == OFF_EDATA) ? acc_nb : CW'(1);
            if (we_i ? wr_ok : rd_ok) begin
              s_start = 1'b1; imm = 1'b0;
            end else if (!we_i) begin
              imm_rd = (addr_i == OFF_EDATA) ? wmask : HDW'(8'hFF);
            end
          end
          default: if (!we_i) imm_rd = HDW'(8'hFF);
        endcase
      end
    end else if (pend_q && !p_req_o) begin
      // second half of a direction change: send the new control value
      s_start = 1'b1;
      s_op    = OP_CTRL;
      s_wbuf  = HDW'(ctrl_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      data_q  <= DATA_RESET;
      ctrl_q  <= CTRL_RESET;
      tmo_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      ack_q  <= (accept && imm) || (seq_done && !pend_q);
      data_q <= data_d;
      ctrl_q <= ctrl_d;
      if (accept && imm)          rdata_q <= imm_rd;
      else if (seq_done && !pend_q) rdata_q <= p_we_o ? '0 : rbuf;
      if (seq_err)      tmo_q <= 1'b1;
      else if (tmo_clr) tmo_q <= 1'b0;
      if (pend_set)                pend_q <= 1'b1;
      else if (pend_q && !p_req_o) pend_q <= 1'b0;
    end
  end

  assign ack_o   = ack_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/epp_gate_chk.sv
module epp_gate_chk
  import epp_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       ecp_sel_i,
  input logic       ack_o,
  input logic       p_req_o,
  input logic [2:0] p_op_o,
  input logic       p_we_o,
  input logic       p_done_i,
  input logic       p_err_i,
  input logic [7:0] ctrl_q,
  input logic       tmo_q,
  input logic       pend_q
);
  logic epp_op;
  assign epp_op = (p_op_o == OP_EPP_ADDR) || (p_op_o == OP_EPP_DATA);

  AST_EPP_WR_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_req_o && p_we_o && epp_op |-> (ctrl_q & CTRL_GATE_MASK) == CTRL_EPP_WR); // R2
  AST_EPP_RD_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_req_o && !p_we_o && epp_op |-> (ctrl_q & CTRL_GATE_MASK) == CTRL_EPP_RD); // R3
  AST_ERR_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_req_o && p_done_i && p_err_i |=> tmo_q); // R5
  AST_TMO_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_q) |-> $past(p_req_o && p_done_i && p_err_i)); // R5
  AST_ECP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && ecp_sel_i && !ack_o && !p_req_o && !pend_q |=> !p_req_o); // R9
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R10
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_req_o && !p_done_i |=> p_req_o && $stable(p_op_o) && $stable(p_we_o)); // R10
  AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    p_req_o |-> !ack_o); // R10
endmodule

bind epp_gate epp_gate_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ecp_sel_i(ecp_sel_i),
  .ack_o(ack_o), .p_req_o(p_req_o), .p_op_o(p_op_o), .p_we_o(p_we_o),
  .p_done_i(p_done_i), .p_err_i(p_err_i), .ctrl_q(ctrl_q), .tmo_q(tmo_q),
  .pend_q(pend_q)
);

// File: tb/test_epp_gate.sv
module test_epp_gate;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, ecp_sel_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic        ack_o;
  logic [31:0] rdata_o;
  logic [7:1]  status_i = '0;
  logic [7:0]  pdata_i = 8'h3C;
  logic        p_req_o, p_we_o;
  logic [2:0]  p_op_o, p_cnt_o;
  logic [7:0]  p_byte_o;
  logic [7:0]  p_rbyte_i = '0;
  logic        p_done_i = 1'b0, p_err_i = 1'b0;

  int total = 0, bad = 0;
  int lcnt = 0, ridx = 0, cyc = 0;
  logic err_mode = 1'b0;
  logic [2:0] lop [64];
  logic [7:0] lbyte [64];
  logic [2:0] lnb [64];
  logic [31:0] rd;

  always #10 clk_i = ~clk_i;

  epp_gate i_epp_gate (.*);

  // peripheral model: completes each byte one cycle after it is requested
  always @(negedge clk_i) begin
    if (p_req_o && !p_done_i) begin
      p_done_i  <= 1'b1;
      p_err_i   <= err_mode;
      p_rbyte_i <= 8'(16 * (ridx + 1));
      if (lcnt < 64) begin
        lop[lcnt]   <= p_op_o;
        lbyte[lcnt] <= p_byte_o;
        lnb[lcnt]   <= p_cnt_o;
      end
      lcnt <= lcnt + 1;
      ridx <= ridx + 1;
    end else begin
      p_done_i <= 1'b0;
      p_err_i  <= 1'b0;
      if (!p_req_o) ridx <= 0;
    end
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic e, input logic [2:0] a,
                        input logic [1:0] s, input logic [31:0] d);
    @(negedge clk_i);
    lcnt = 0;
    we_i = w; ecp_sel_i = e; addr_i = a; size_i = s; wdata_i = d; req_i = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk_i);
      cyc++;
    end while (!ack_o && cyc < 1000);
    rd = rdata_o;
    req_i = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic        ecp;
    logic [2:0]  off;
    logic [1:0]  sz;
    logic [31:0] wd;
    logic [7:0]  st;
    logic [31:0] exp;
    logic [2:0]  nb;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{0,0,3'd2,2'd0,32'h0,        8'hA5,32'hCC,      3'd0,4'd1},  // R1 control reset
    '{0,0,3'd0,2'd0,32'h0,        8'hA5,32'hFF,      3'd0,4'd1},  // R1 data reset
    '{0,0,3'd1,2'd0,32'h0,        8'hA5,32'hA4,      3'd0,4'd6},  // R6 bit0 = flag
    '{1,0,3'd3,2'd0,32'h12,       8'hA5,32'h0,       3'd0,4'd2},  // R2 closed gate
    '{0,0,3'd4,2'd0,32'h0,        8'hA5,32'hFF,      3'd0,4'd3},  // R3 closed gate
    '{1,0,3'd2,2'd0,32'h04,       8'hA5,32'h0,       3'd1,4'd7},  // R7 new control
    '{1,0,3'd2,2'd0,32'h04,       8'hA5,32'h0,       3'd0,4'd7},  // R7 same control
    '{1,0,3'd3,2'd0,32'h12,       8'hA5,32'h0,       3'd1,4'd2},  // R2 open gate
    '{1,0,3'd4,2'd2,32'h11223344, 8'hA5,32'h0,       3'd4,4'd4},  // R4 word write
    '{0,0,3'd4,2'd2,32'h0,        8'hA5,32'hFFFFFFFF,3'd0,4'd3},  // R3 word mask
    '{0,0,3'd4,2'd1,32'h0,        8'hA5,32'h0000FFFF,3'd0,4'd3},  // R3 half mask
    '{1,0,3'd0,2'd0,32'h5A,       8'hA5,32'h0,       3'd1,4'd7},  // R7 new data
    '{1,0,3'd0,2'd0,32'h5A,       8'hA5,32'h0,       3'd0,4'd7},  // R7 same data
    '{1,1,3'd0,2'd0,32'h33,       8'hA5,32'h0,       3'd0,4'd9},  // R9 window write
    '{0,1,3'd3,2'd0,32'h0,        8'hA5,32'hFF,      3'd0,4'd9},  // R9 window read
    '{1,0,3'd2,2'd0,32'h24,       8'hA5,32'h0,       3'd2,4'd8},  // R8 dir change
    '{0,0,3'd4,2'd2,32'h0,        8'hA5,32'h40302010,3'd4,4'd4},  // R4 word read
    '{0,0,3'd3,2'd0,32'h0,        8'hA5,32'h10,      3'd1,4'd3},  // R3 open gate
    '{0,0,3'd0,2'd0,32'h0,        8'hA5,32'h3C,      3'd0,4'd11}, // R11 dir=1
    '{1,0,3'd3,2'd0,32'h12,       8'hA5,32'h0,       3'd0,4'd2},  // R2 read dir
    '{0,0,3'd1,2'd0,32'h0,        8'h5E,32'h5E,      3'd0,4'd6}   // R6 live lines
  };

  initial begin
    repeat (100000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 idle request", 32'(p_req_o), 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      status_i = VECS[i].st[7:1];
      access(VECS[i].we, VECS[i].ecp, VECS[i].off, VECS[i].sz, VECS[i].wd);
      check($sformatf("R%0d vec%0d rdata", VECS[i].rq, i), rd, VECS[i].exp);
      check($sformatf("R%0d vec%0d bytes", VECS[i].rq, i), 32'(lcnt), 32'(VECS[i].nb));
    end

    // R8: direction request ahead of control byte
    access(1, 0, 3'd2, 2'd0, 32'h04);
    check("R8 count", 32'(lcnt), 32'd2);
    check("R8 first op", 32'(lop[0]), 32'd4);
    check("R8 first byte", 32'(lbyte[0]), 32'h00);
    check("R8 second op", 32'(lop[1]), 32'd3);
    check("R8 second byte", 32'(lbyte[1]), 32'hC4);

    // R4 order, R10 stall length
    access(1, 0, 3'd4, 2'd1, 32'h0000BEEF);
    check("R4 half count", 32'(lcnt), 32'd2);
    check("R4 byte0", 32'(lbyte[0]), 32'hEF);
    check("R4 byte1", 32'(lbyte[1]), 32'hBE);
    check("R4 cnt field", 32'(lnb[0]), 32'd2);
    check("R4 op", 32'(lop[0]), 32'd1);
    check("R10 stall cycles", 32'(cyc), 32'd4);
    @(negedge clk_i);
    check("R10 ack pulse", 32'(ack_o), 32'h0);
    access(0, 0, 3'd2, 2'd0, 32'h0);
    check("R10 immediate cycles", 32'(cyc), 32'd1);

    // R5: error aborts and latches
    access(1, 0, 3'd2, 2'd0, 32'h24);
    err_mode = 1'b1;
    access(0, 0, 3'd4, 2'd2, 32'h0);
    err_mode = 1'b0;
    check("R5 aborted count", 32'(lcnt), 32'd1);
    check("R5 read ones", rd, 32'hFFFFFFFF);
    access(0, 0, 3'd3, 2'd0, 32'h0);
    check("R5 later read ok", rd, 32'h10);
    status_i = 7'h52;
    access(0, 0, 3'd1, 2'd0, 32'h0);
    check("R5 flag sticky", rd, 32'hA5);
    access(1, 0, 3'd1, 2'd0, 32'hFE);
    access(0, 0, 3'd1, 2'd0, 32'h0);
    check("R6 write 0 keeps", rd, 32'hA5);
    access(1, 0, 3'd1, 2'd0, 32'h01);
    access(0, 0, 3'd1, 2'd0, 32'h0);
    check("R6 write 1 clears", rd, 32'hA4);

    // R1: reset in the middle of a word read
    access(1, 0, 3'd2, 2'd0, 32'h24);
    @(negedge clk_i);
    we_i = 1'b0; ecp_sel_i = 1'b0; addr_i = 3'd4; size_i = 2'd2; req_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    req_i = 1'b0;
    @(negedge clk_i);
    check("R1 request dropped", 32'(p_req_o), 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    access(0, 0, 3'd2, 2'd0, 32'h0);
    check("R1 control after reset", rd, 32'hCC);
    access(0, 0, 3'd1, 2'd0, 32'h0);
    check("R1 flag after reset", rd, 32'hA4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule